// File: doc/BRIEF.md
# I2C Master Interrupt Status Unit

This block gathers the interrupt events of an I2C master controller into one status word, decides which of them reach the interrupt line, and lets software acknowledge them. Ten of the twelve sources are sticky. A one-cycle event pulse sets the bit, and the bit stays set until software clears it. The receive-threshold and transmit-threshold sources are not sticky: their bits follow the FIFO level inputs directly. A mask register chooses which status bits appear in the masked status word. The same mask chooses which bits drive the interrupt output.

Software acknowledges sources by reading clear addresses. Each source has its own clear address, and a read there clears only that source. This lets a handler read the masked status and then clear exactly the bits it saw. An event that lands between the status read and the clear read stays pending. A further clear-all address clears every sticky source at once.

An abort-cause register records the reasons for a transfer abort. Whenever the abort event pulses, it ORs in the cause vector supplied with that event. The abort clear read empties this register, and so does the clear-all read. The event generators sit outside this block.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the mask register reads 0x254, so the receive-threshold (bit 2), transmit-threshold (bit 4), abort (bit 6) and stop-detected (bit 9) sources are enabled. After reset the raw status reads 0 when both threshold inputs are low, and the abort-cause register reads 0.
- R2: A pulse on `evt_i[i]` sets raw status bit i, and the bit stays set until it is cleared. This holds for every source except bits 2 and 4. The status bits are: 0 rx underflow, 1 rx overflow, 3 tx overflow, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop detected, 10 start detected, 11 general call.
- R3: Raw status bit 2 equals `rx_thr_i` and raw status bit 4 equals `tx_thr_i` in the same cycle. `evt_i[2]`, `evt_i[4]` and the clear reads for bits 2 and 4 have no effect on these bits.
- R4: A write to address 0x00 loads the mask from `wdata_i[11:0]`. Writes to any other address change nothing.
- R5: A read at the masked status address 0x02 returns the raw status ANDed with the mask. A read at 0x00 returns the mask, at 0x01 the raw status, and at 0x03 the abort cause, zero-extended to 16 bits.
- R6: A read at address 0x10+i (i from 0 to 11) clears raw status bit i only, and leaves every other bit as it was.
- R7: A read at address 0x04 clears all sticky status bits and the abort-cause register.
- R8: While `evt_i[6]` pulses, the abort-cause register ORs in `cause_i`. Cause bit positions: 0 7-bit address nack, 1 10-bit first address nack, 2 10-bit second address nack, 3 data nack, 4 general-call nack, 5 general-call read, 7 start byte acked, 9 start byte with restart off, 10 10-bit read with restart off, 11 master disabled, 12 arbitration lost. A read at 0x16 (the abort clear) empties the register.
- R9: If an event pulse arrives in the same cycle as a read that clears its bit, the bit remains set. For the abort source, the abort-cause register then holds exactly that cycle's `cause_i`.
- R10: `irq_o` is high exactly when at least one bit of the masked status is set.
- R11: `rdata_o` is combinational and is 0 when `rd_en_i` is low, on clear-address reads, and on reads of unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 6 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the cycle of `rd_en_i` |
| evt_i | input | 12 | One-cycle event pulses, one per status bit |
| rx_thr_i | input | 1 | Receive FIFO at or above threshold |
| tx_thr_i | input | 1 | Transmit FIFO at or below threshold |
| cause_i | input | 13 | Abort reasons, sampled while `evt_i[6]` pulses |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a clear read and the matching event pulse landing in the same cycle. This case separates a design that lets the event win from one that loses it. The case matters most for the abort source, where the cause register must end up holding only the new reasons. The stimulus lines up a clear read of bit 6 with an abort pulse carrying a fresh cause vector, and does the same for an ordinary sticky bit. It also applies the clear-all read together with an event. A reference model in the bench is compared with `rdata_o` and `irq_o` on every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_SRC      = 12;
    localparam int CAUSE_BITS   = 13;
    localparam int BIT_RX_LVL   = 2;
    localparam int BIT_TX_LVL   = 4;
    localparam int BIT_ABORT    = 6;
    localparam int BIT_STOP     = 9;
    localparam logic [NUM_SRC-1:0] LEVEL_BITS =
        NUM_SRC'((1 << BIT_RX_LVL) | (1 << BIT_TX_LVL));
    localparam logic [NUM_SRC-1:0] RESET_MASK =
        NUM_SRC'((1 << BIT_RX_LVL) | (1 << BIT_TX_LVL) | (1 << BIT_ABORT) | (1 << BIT_STOP));
    localparam int A_MASK       = 'h00;
    localparam int A_RAW        = 'h01;
    localparam int A_MASKED     = 'h02;
    localparam int A_CAUSE      = 'h03;
    localparam int A_CLR_ALL    = 'h04;
    localparam int A_CLR_BASE   = 'h10;
endpackage

// File: rtl/irq_clr_decode.sv
module irq_clr_decode
    import irq_pkg::*;
#(
    parameter int NSRC   = NUM_SRC,
    parameter int ADDR_W = 6
) (
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NSRC-1:0]   clr_o,
    output logic              clr_all_o
);
    always_comb begin
        clr_all_o = rd_en_i && (addr_i == ADDR_W'(A_CLR_ALL));
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_clr
        assign clr_o[i] = clr_all_o || (rd_en_i && (addr_i == ADDR_W'(A_CLR_BASE + i)));
    end
endmodule

// File: rtl/irq_status_bits.sv
module irq_status_bits
    import irq_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter logic [NSRC-1:0] LEVEL_MAP = LEVEL_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic [NSRC-1:0] lvl_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] raw_o
);
    logic [NSRC-1:0] sticky_d, sticky_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        if (LEVEL_MAP[i]) begin : g_level
            assign sticky_d[i] = 1'b0;
            assign raw_o[i]    = lvl_i[i];
        end else begin : g_sticky
            // pulse wins over a clear in the same cycle
            assign sticky_d[i] = evt_i[i] | (sticky_q[i] & ~clr_i[i]);
            assign raw_o[i]    = sticky_q[i];

            a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
                evt_i[i] |=> raw_o[i]);
            a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[i] && !evt_i[i]) |=> !raw_o[i]);
            a_r2_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
                (raw_o[i] && !clr_i[i]) |=> raw_o[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= sticky_d;
    end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_pkg::*;
#(
    parameter int NSRC    = NUM_SRC,
    parameter int CAUSE_W = CAUSE_BITS,
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    input  logic [NSRC-1:0]    evt_i,
    input  logic               rx_thr_i,
    input  logic               tx_thr_i,
    input  logic [CAUSE_W-1:0] cause_i,
    output logic               irq_o
);
    typedef struct packed {
        logic [NSRC-1:0]    mask;
        logic [CAUSE_W-1:0] cause;
    } ctrl_t;

    ctrl_t           st_d, st_q;
    logic [NSRC-1:0] clr_vec;
    logic            clr_all;
    logic [NSRC-1:0] lvl_vec;
    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] masked;
    logic            abort_evt;
    logic            abort_clr;

    always_comb begin
        lvl_vec             = '0;
        lvl_vec[BIT_RX_LVL] = rx_thr_i;
        lvl_vec[BIT_TX_LVL] = tx_thr_i;
    end

    irq_clr_decode #(.NSRC(NSRC), .ADDR_W(ADDR_W)) i_decode (
        .rd_en_i  (rd_en_i),
        .addr_i   (addr_i),
        .clr_o    (clr_vec),
        .clr_all_o(clr_all)
    );

    irq_status_bits #(.NSRC(NSRC), .LEVEL_MAP(LEVEL_BITS)) i_bits (
        .clk  (clk),
        .rst_n(rst_n),
        .evt_i(evt_i),
        .lvl_i(lvl_vec),
        .clr_i(clr_vec),
        .raw_o(raw)
    );

    assign abort_evt = evt_i[BIT_ABORT];
    assign abort_clr = clr_vec[BIT_ABORT];
    assign masked    = raw & st_q.mask;
    assign irq_o     = |masked;

    always_comb begin
        st_d = st_q;
        if (wr_en_i && (addr_i == ADDR_W'(A_MASK)))
            st_d.mask = wdata_i[NSRC-1:0];
        st_d.cause = (abort_clr ? '0 : st_q.cause) | (abort_evt ? cause_i : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask  <= RESET_MASK;
            st_q.cause <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            if (addr_i == ADDR_W'(A_MASK))        rdata_o = DATA_W'(st_q.mask);
            else if (addr_i == ADDR_W'(A_RAW))    rdata_o = DATA_W'(raw);
            else if (addr_i == ADDR_W'(A_MASKED)) rdata_o = DATA_W'(masked);
            else if (addr_i == ADDR_W'(A_CAUSE))  rdata_o = DATA_W'(st_q.cause);
        end
    end

    a_r8_cause_wiped: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_clr && !abort_evt) |=> (st_q.cause == '0));
    a_r8_cause_captured: assert property (@(posedge clk) disable iff (!rst_n)
        abort_evt |=> ((st_q.cause & $past(cause_i)) == $past(cause_i)));
    a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & st_q.mask) == '0) |-> !irq_o);
    a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && (evt_i == '0)) |=> ((raw & ~LEVEL_BITS) == '0));
    a_r4_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(st_q.mask));
endmodule

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [11:0] evt = '0;
    logic        rx_thr = 1'b0, tx_thr = 1'b0;
    logic [12:0] cause = '0;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // reference model state
    logic [11:0] m_sticky = '0;
    logic [11:0] m_mask   = 12'h254;
    logic [12:0] m_cause  = '0;

    irq_status_ctrl i_irq_status_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt),
        .rx_thr_i(rx_thr), .tx_thr_i(tx_thr), .cause_i(cause), .irq_o(irq)
    );

    always #4 clk = ~clk;

    function automatic logic [11:0] m_raw();
        logic [11:0] r;
        r = m_sticky;
        r[2] = rx_thr;
        r[4] = tx_thr;
        return r;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: drive after negedge, compare before posedge, update model after it
    task automatic cyc(input logic w, input logic r, input logic [5:0] a,
                       input logic [15:0] wd, input logic [11:0] ev,
                       input logic [12:0] ci, input string tag);
        logic [15:0] exp_rd;
        logic [11:0] clr;
        logic [11:0] raw;
        wr_en = w; rd_en = r; addr = a; wdata = wd; evt = ev; cause = ci;
        #2;
        raw = m_raw();
        exp_rd = '0;
        if (r) begin
            case (a)
                6'h00: exp_rd = {4'h0, m_mask};
                6'h01: exp_rd = {4'h0, raw};
                6'h02: exp_rd = {4'h0, raw & m_mask};
                6'h03: exp_rd = {3'h0, m_cause};
                default: exp_rd = '0;
            endcase
        end
        check({tag, " rdata"}, rdata, exp_rd);
        check({tag, " irq R10"}, {15'h0, irq}, {15'h0, |(raw & m_mask)});
        @(posedge clk);
        clr = '0;
        if (r && a == 6'h04) clr = 12'hFFF;
        if (r && a >= 6'h10 && a <= 6'h1B) clr[a - 6'h10] = 1'b1;
        if (w && a == 6'h00) m_mask = wd[11:0];
        m_sticky = ((m_sticky & ~clr) | ev) & 12'hFEB;
        m_cause  = (clr[6] ? 13'h0 : m_cause) | (ev[6] ? ci : 13'h0);
        @(negedge clk);
        wr_en = 0; rd_en = 0; evt = '0; cause = '0;
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        cyc(1'b0, 1'b1, a, 16'h0, 12'h0, 13'h0, tag);
    endtask

    task automatic pulse(input logic [11:0] ev, input logic [12:0] ci, input string tag);
        cyc(1'b0, 1'b0, 6'h00, 16'h0, ev, ci, tag);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(6'h00, "R1 mask");
        rd(6'h01, "R1 raw");
        rd(6'h03, "R1 cause");
        rd(6'h02, "R1 masked");

        // R2 each sticky bit, set then kept
        for (int i = 0; i < 12; i++) begin
            pulse(12'(1 << i), 13'h0, "R2 pulse");
            pulse(12'h0, 13'h0, "R2 idle");
            rd(6'h01, "R2 raw");
            rd(6'h04, "R7 clear all");
            rd(6'h01, "R7 raw after");
        end

        // R3 level bits
        rx_thr = 1'b1;
        rd(6'h01, "R3 rx level");
        tx_thr = 1'b1;
        rd(6'h02, "R3 both levels");
        rd(6'h12, "R3 clear rx ignored");
        rd(6'h14, "R3 clear tx ignored");
        rd(6'h01, "R3 raw after clears");
        rx_thr = 1'b0; tx_thr = 1'b0;
        pulse(12'h014, 13'h0, "R3 pulse ignored");
        rd(6'h01, "R3 raw after pulses");

        // R4/R5 mask writes
        cyc(1'b1, 1'b0, 6'h00, 16'hFFFF, 12'h0, 13'h0, "R4 write mask");
        rd(6'h00, "R4 mask readback");
        cyc(1'b1, 1'b0, 6'h01, 16'h0000, 12'h0, 13'h0, "R4 stray write");
        rd(6'h00, "R4 mask unchanged");
        pulse(12'hA81, 13'h0, "R5 set sources");
        rd(6'h02, "R5 masked full");
        cyc(1'b1, 1'b0, 6'h00, 16'h0080, 12'h0, 13'h0, "R4 narrow mask");
        rd(6'h02, "R5 masked narrow");
        cyc(1'b1, 1'b0, 6'h00, 16'h0000, 12'h0, 13'h0, "R10 mask off");
        rd(6'h02, "R10 irq quiet");

        // R6 per-source clear
        cyc(1'b1, 1'b0, 6'h00, 16'h0FFF, 12'h0, 13'h0, "R6 mask all");
        rd(6'h17, "R6 clear bit7");
        rd(6'h01, "R6 raw after bit7");
        rd(6'h1B, "R6 clear bit11");
        rd(6'h10, "R6 clear bit0");
        rd(6'h01, "R6 raw remaining");
        rd(6'h19, "R6 clear bit9");
        rd(6'h02, "R6 all clear");

        // R8 abort cause
        pulse(12'h040, 13'h1009, "R8 abort one");
        rd(6'h03, "R8 cause one");
        pulse(12'h040, 13'h0800, "R8 abort two");
        rd(6'h03, "R8 cause or");
        rd(6'h16, "R8 abort clear");
        rd(6'h03, "R8 cause wiped");
        rd(6'h01, "R8 raw wiped");

        // R9 event and clear in one cycle
        pulse(12'h040, 13'h0003, "R9 abort first");
        cyc(1'b0, 1'b1, 6'h16, 16'h0, 12'h040, 13'h1000, "R9 abort clear race");
        rd(6'h03, "R9 cause new only");
        rd(6'h01, "R9 abort kept");
        pulse(12'h008, 13'h0, "R9 set bit3");
        cyc(1'b0, 1'b1, 6'h13, 16'h0, 12'h008, 13'h0, "R9 bit3 race");
        rd(6'h01, "R9 bit3 kept");
        cyc(1'b0, 1'b1, 6'h04, 16'h0, 12'h400, 13'h0, "R9 clear all race");
        rd(6'h01, "R9 bit10 kept");
        rd(6'h03, "R7 cause cleared by all");

        // R11 unmapped and idle reads
        rd(6'h3F, "R11 unmapped");
        rd(6'h08, "R11 unmapped low");
        pulse(12'h0, 13'h0, "R11 idle");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule